// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for each incoming Ethernet frame, whether the frame is kept. The decision uses the frame's 48-bit destination address. An upstream parser presents the six address bytes together with a one-cycle strobe. One clock later the filter returns an accept or reject verdict, and a flag that says whether the accept came from an exact station match.

The filter has two stages. The first is a bank of station entries that are compared against the address all at once. The second is a 4096-bit multicast hash table. It is consulted only when no valid station entry matches. Its index is taken from the top two address bytes at a bit offset that software selects. A saturating counter records how many frames were accepted through the hash table.

All state is loaded through a word-wide write port: the station entries, the hash table and the offset selector.

Top module: `rx_addr_screen`

## Requirements
- R1: After reset the result-valid output and the hash-hit counter are zero, every station entry is invalid and every hash bit is clear, so any lookup is rejected.
- R2: A lookup strobe sampled on a clock edge produces the verdict on the outputs after that same edge. The result-valid output is high for exactly one cycle per strobe.
- R3: Station entry n is written at word address 2n (address bytes 0 to 3, byte 0 in bits 7:0) and at word address 2n+1 (byte 4 in bits 7:0, byte 5 in bits 15:0's upper half, valid flag in bit 31). A lookup equal to any valid entry is accepted with the exact flag set.
- R4: An entry whose valid flag (bit 31 of its odd word) is clear never matches, even when its stored address equals the lookup.
- R5: When an exact match occurs, the hash table is not consulted and the counter does not change, even if the frame's hash bit is set.
- R6: Without an exact match, the value {byte5, byte4} is shifted right by 4, 3, 2 or 0 for offset code 0, 1, 2 or 3. The offset code is written to bits 1:0 of word address 32. The low 12 bits of the shifted value form the hash index.
- R7: Hash word k sits at word address 128+k. Index bits 11:5 select the word and bits 4:0 select the bit. A set bit accepts the frame with the exact flag clear.
- R8: Each hash-path accept adds one to the counter. Once the counter holds its maximum value it stays there.
- R9: A frame that matches no valid entry and whose hash bit is clear is rejected, and the counter is unchanged.
- R10: All 16 station entries take part in matching, including the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Word address of the write |
| wrData | input | 32 | Write data |
| daValid | input | 1 | Destination address present this cycle |
| daBytes | input | 48 | Destination address, byte 0 in bits 7:0 |
| resValid | output | 1 | Verdict valid |
| resAccept | output | 1 | Frame accepted |
| resExact | output | 1 | Accept came from a station entry |
| hashCount | output | CNT_W | Saturating count of hash-path accepts |

## Verification
The hardest case to reach is a frame that satisfies both the station table and the hash table at once, because that is the only case where the precedence of R5 can be seen. The bench sets the hash bit that belongs to a programmed station address, so that case arises. It then clears that entry's valid flag and shows that the same frame now lands on the hash path and is counted. Counter saturation needs many hash hits, so the bench instantiates a narrow counter and repeats a hash-hitting frame until the counter reaches its ceiling.

// File: rtl/rx_addr_screen_pkg.sv
package rx_addr_screen_pkg;
  localparam int REG_AW    = 8;
  localparam int CFG_ADDR  = 32;
  localparam int HASH_BASE = 128;
  localparam int VALID_BIT = 31;

  typedef struct packed {
    logic              entryWe;
    logic              entryHi;
    logic              hashWe;
    logic              lookup;
    logic [REG_AW-1:0] slot;
  } ctlStrobe_t;
endpackage

// File: rtl/rx_addr_screen_ctl.sv
module rx_addr_screen_ctl
  import rx_addr_screen_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [1:0]        cfgBits,
  input  logic              daValid,
  output ctlStrobe_t        strobe,
  output logic [1:0]        mcOffset,
  output logic              resValid
);
  localparam int ENTRY_WORDS = 2 * NUM_ENTRIES;

  logic inEntry, inHash, cfgWe;

  always_comb begin
    inEntry = wrAddr < REG_AW'(ENTRY_WORDS);
    inHash  = wrAddr >= REG_AW'(HASH_BASE);
    cfgWe   = wrEn && (wrAddr == REG_AW'(CFG_ADDR));
    strobe.entryWe = wrEn && inEntry;
    strobe.entryHi = wrAddr[0];
    strobe.hashWe  = wrEn && inHash;
    strobe.lookup  = daValid;
    if (inHash) strobe.slot = wrAddr - REG_AW'(HASH_BASE);
    else        strobe.slot = wrAddr >> 1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mcOffset <= 2'd0;
      resValid <= 1'b0;
    end else begin
      if (cfgWe) mcOffset <= cfgBits;
      resValid <= daValid;
    end
  end

  assert_one_target_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.entryWe, strobe.hashWe, cfgWe}));
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lookup |=> resValid);
  assert_valid_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.lookup |=> !resValid);
endmodule

// File: rtl/rx_addr_screen_dp.sv
module rx_addr_screen_dp
  import rx_addr_screen_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int HASH_WORDS  = 128,
  parameter int CNT_W       = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [31:0]      wrData,
  input  logic [1:0]       mcOffset,
  input  logic [47:0]      daBytes,
  output logic             resAccept,
  output logic             resExact,
  output logic [CNT_W-1:0] hashCount
);
  localparam int ENT_W = $clog2(NUM_ENTRIES);
  localparam int HW_AW = $clog2(HASH_WORDS);
  localparam int IDX_W = HW_AW + 5;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [31:0] loWord [NUM_ENTRIES];
  logic [31:0] hiWord [NUM_ENTRIES];
  logic [31:0] hashMem [HASH_WORDS];
  logic [NUM_ENTRIES-1:0] hitVec;
  logic anyExact, hashHit, countUp;
  logic [15:0] shifted;
  logic [IDX_W-1:0] hashIdx;
  logic unusedBits;

  assign unusedBits = ^{strobe.slot, shifted};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        loWord[i] <= '0;
        hiWord[i] <= '0;
      end
    end else if (strobe.entryWe) begin
      if (strobe.entryHi) hiWord[strobe.slot[ENT_W-1:0]] <= wrData;
      else                loWord[strobe.slot[ENT_W-1:0]] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < HASH_WORDS; k++) hashMem[k] <= '0;
    end else if (strobe.hashWe) begin
      hashMem[strobe.slot[HW_AW-1:0]] <= wrData;
    end
  end

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gCmp
    assign hitVec[g] = hiWord[g][VALID_BIT]
                    && (loWord[g] == daBytes[31:0])
                    && (hiWord[g][15:0] == daBytes[47:32]);
  end

  always_comb begin
    anyExact = |hitVec;
    case (mcOffset)
      2'd0:    shifted = daBytes[47:32] >> 4;
      2'd1:    shifted = daBytes[47:32] >> 3;
      2'd2:    shifted = daBytes[47:32] >> 2;
      default: shifted = daBytes[47:32];
    endcase
    hashIdx = shifted[IDX_W-1:0];
    hashHit = hashMem[hashIdx[IDX_W-1:5]][hashIdx[4:0]];
    countUp = strobe.lookup && !anyExact && hashHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resAccept <= 1'b0;
      resExact  <= 1'b0;
      hashCount <= '0;
    end else begin
      resAccept <= strobe.lookup && (anyExact || hashHit);
      resExact  <= strobe.lookup && anyExact;
      if (countUp && hashCount != CNT_MAX) hashCount <= hashCount + 1'b1;
    end
  end

  assert_exact_accepts_R3: assert property (@(posedge clk) disable iff (!rstN)
    resExact |-> resAccept);
  assert_count_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hashCount != $past(hashCount)) |-> (resAccept && !resExact));
  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hashCount != $past(hashCount)) |-> (hashCount == $past(hashCount) + 1'b1));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hashCount == CNT_MAX) |=> (hashCount == CNT_MAX));
endmodule

// File: rtl/rx_addr_screen.sv
module rx_addr_screen
  import rx_addr_screen_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int HASH_WORDS  = 128,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic              daValid,
  input  logic [47:0]       daBytes,
  output logic              resValid,
  output logic              resAccept,
  output logic              resExact,
  output logic [CNT_W-1:0]  hashCount
);
  ctlStrobe_t strobe;
  logic [1:0] mcOffset;

  rx_addr_screen_ctl #(.NUM_ENTRIES(NUM_ENTRIES)) uCtl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .cfgBits(wrData[1:0]), .daValid(daValid), .strobe(strobe),
    .mcOffset(mcOffset), .resValid(resValid)
  );

  rx_addr_screen_dp #(.NUM_ENTRIES(NUM_ENTRIES), .HASH_WORDS(HASH_WORDS),
                      .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .mcOffset(mcOffset), .daBytes(daBytes), .resAccept(resAccept),
    .resExact(resExact), .hashCount(hashCount)
  );
endmodule

// File: tb/rx_addr_screen_test.sv
module rx_addr_screen_test;
  localparam int CW = 4;
  localparam int NV = 12;

  typedef struct packed {
    logic [1:0]  off;
    logic [47:0] mac;
    logic        acc;
    logic        exact;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{2'd0, 48'h5544_3322_1102, 1'b1, 1'b1},
    '{2'd0, 48'hFFEE_DDCC_BB0A, 1'b1, 1'b1},
    '{2'd0, 48'h0504_0302_0106, 1'b0, 1'b0},
    '{2'd0, 48'h3412_005E_0001, 1'b1, 1'b0},
    '{2'd1, 48'h3412_005E_0001, 1'b0, 1'b0},
    '{2'd2, 48'h3412_005E_0001, 1'b1, 1'b0},
    '{2'd3, 48'h3412_005E_0001, 1'b0, 1'b0},
    '{2'd3, 48'h5644_3322_1102, 1'b0, 1'b0},
    '{2'd3, 48'h5544_3322_1102, 1'b1, 1'b1},
    '{2'd1, 48'hFFEE_DDCC_BB0A, 1'b1, 1'b1},
    '{2'd3, 48'hCDAB_0000_0033, 1'b1, 1'b0},
    '{2'd0, 48'hCDAB_0000_0033, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, daValid = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [47:0] daBytes = '0;
  logic resValid, resAccept, resExact;
  logic [CW-1:0] hashCount;
  int checks = 0, fails = 0, expCount = 0;
  logic [31:0] shadow [128];
  logic [1:0] curOff = 2'd0;

  always #10 clk = ~clk;

  rx_addr_screen #(.CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .daValid(daValid), .daBytes(daBytes), .resValid(resValid),
    .resAccept(resAccept), .resExact(resExact), .hashCount(hashCount)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  function automatic logic [11:0] idxOf(input logic [47:0] m, input logic [1:0] o);
    logic [15:0] v = m[47:32];
    case (o)
      2'd0: v = v >> 4;
      2'd1: v = v >> 3;
      2'd2: v = v >> 2;
      default: v = v;
    endcase
    return v[11:0];
  endfunction

  task automatic setHash(input logic [47:0] m, input logic [1:0] o);
    logic [11:0] ix = idxOf(m, o);
    shadow[ix[11:5]][ix[4:0]] = 1'b1;
    wr(8'd128 + {1'b0, ix[11:5]}, shadow[ix[11:5]]);
  endtask

  task automatic lookup(input string req, input logic [47:0] m,
                        input logic acc, input logic exact);
    @(negedge clk); daValid = 1'b1; daBytes = m;
    @(negedge clk); daValid = 1'b0;
    if (acc && !exact && expCount < (1 << CW) - 1) expCount++;
    check({req, " valid"}, {31'd0, resValid}, 32'd1);
    check({req, " accept"}, {31'd0, resAccept}, {31'd0, acc});
    check({req, " exact"}, {31'd0, resExact}, {31'd0, exact});
    check({req, " count"}, {28'd0, hashCount}, expCount);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 valid", {31'd0, resValid}, 32'd0);
    check("R1 count", {28'd0, hashCount}, 32'd0);
    lookup("R1 empty", 48'h5544_3322_1102, 1'b0, 1'b0);
    // R2 single-cycle valid
    @(negedge clk);
    check("R2 pulse", {31'd0, resValid}, 32'd0);

    // R3/R10 entries 0 and 15; R4 entry 5 invalid
    wr(8'd0, 32'h3322_1102);  wr(8'd1, 32'h8000_5544);
    wr(8'd30, 32'hDDCC_BB0A); wr(8'd31, 32'h8000_FFEE);
    wr(8'd10, 32'h0302_0106); wr(8'd11, 32'h0000_0504);
    // R7 hash bits; R5 bit under entry 0
    setHash(48'h3412_005E_0001, 2'd0);
    setHash(48'h3412_005E_0001, 2'd2);
    setHash(48'h5544_3322_1102, 2'd0);
    setHash(48'hCDAB_0000_0033, 2'd3);

    // table walk: R3 R4 R5 R6 R7 R9 R10
    for (int v = 0; v < NV; v++) begin
      if (VEC[v].off != curOff) begin
        curOff = VEC[v].off;
        wr(8'd32, {30'd0, curOff});
      end
      lookup($sformatf("R6/R7/R9 vec%0d", v), VEC[v].mac, VEC[v].acc, VEC[v].exact);
    end

    // R4 clear valid of entry 0: falls through to hash (R5 bit set at offset 0)
    wr(8'd32, 32'd0);
    wr(8'd1, 32'h0000_5544);
    lookup("R4 cleared entry", 48'h5544_3322_1102, 1'b1, 1'b0);
    // R10 last entry still exact
    lookup("R10 last entry", 48'hFFEE_DDCC_BB0A, 1'b1, 1'b1);
    // R8 saturation
    for (int n = 0; n < 20; n++) lookup("R8 saturate", 48'h3412_005E_0001, 1'b1, 1'b0);
    check("R8 ceiling", {28'd0, hashCount}, 32'd15);
    // R9 reject leaves counter
    lookup("R9 reject", 48'h0000_0000_0000, 1'b0, 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule